// File: doc/BRIEF.md
# Nibble-Serial Instruction Field Assembler

This block builds variable-length instructions from a stream of encoded bytes. It takes at most one byte per cycle. Each byte picks one of four instruction fields and carries a 4-bit chunk. The chunk is shifted into the low end of the chosen field. The field may first be bitwise complemented, which lets a short run of bytes encode a sign-extended negative immediate. Every byte except the last of an instruction has its hold flag set. The byte with hold clear completes the instruction. The finished instruction then goes to a registered valid/ready output slot, together with its start address, its byte count, the four field values, the downstream epoch and the sequential next address.

Bytes come from an aligned line buffer. The block presents its current decode address. A line is usable only when it is valid and its line address matches that decode address. The byte is then picked at the address's offset within the line. A restart loads a new decode address and epoch and abandons any partial instruction. Branch prediction lies outside this block. The predicted next address is the sequential one.

Top module: `nibble_inst_asm`

## Requirements
- R1: After reset, `inst_valid_o` is 0, `decode_pc_o` is 0, and the partial instruction is empty.
- R2: A byte is consumed (`byte_take_o` high) only in a cycle with all of the following: `bundle_valid_i` is high, `bundle_line_i` equals `decode_pc_o` shifted right by log2(LINE_BYTES), the output slot is empty or being accepted, and `restart_valid_i` is low. The consumed byte is the one at the decode address's offset in the line, and at most one byte is consumed per cycle.
- R3: Encoded byte layout: bits [3:0] are the nibble value. Bits [5:4] are the field index: 0 opcode, 1 flags/destination, 2 source 1, 3 source 2. Bit 6 is invert and bit 7 is hold.
- R4: For a consumed byte, the selected field is complemented if invert is set. It is then shifted left by 4 with the nibble placed in bits [3:0]. Fields are FIELD_W bits wide, bits shifted out of the top are lost, and unselected fields keep their value.
- R5: Each consumed byte advances the decode address by one and the byte count by one.
- R6: A consumed byte with hold clear makes `inst_valid_o` high in the next cycle. The output then carries the fields, including that byte's update, the epoch, and next and predicted next addresses both equal to start address plus byte count.
- R7: After an instruction completes, every field is cleared, the byte count restarts at 0, and the next instruction's start address is the address after the completing byte.
- R8: While the byte count is at or above MAX_BYTES, no byte is consumed and the decode address holds until a restart.
- R9: A restart sets the decode and start addresses to `restart_pc_i`, clears fields and byte count, and latches `restart_epoch_i` for later instructions. It takes priority over byte consumption.
- R10: While `inst_valid_o` is high and `inst_ready_i` is low, the output valid and payload stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_valid_i | input | 1 | Load a new decode address and epoch |
| restart_pc_i | input | PC_W | New decode address |
| restart_epoch_i | input | EPOCH_W | Epoch for following instructions |
| bundle_valid_i | input | 1 | Line buffer entry is valid |
| bundle_line_i | input | PC_W-log2(LINE_BYTES) | Line address of the entry |
| bundle_data_i | input | LINE_BYTES*8 | Line bytes, byte 0 in bits [7:0] |
| decode_pc_o | output | PC_W | Current decode address |
| byte_take_o | output | 1 | A byte is consumed this cycle |
| inst_valid_o | output | 1 | Completed instruction available |
| inst_ready_i | input | 1 | Consumer accepts the instruction |
| inst_start_pc_o | output | PC_W | Address of the first byte |
| inst_size_o | output | SIZE_W | Byte count |
| inst_opcode_o | output | FIELD_W | Field 0 |
| inst_flags_dst_o | output | FIELD_W | Field 1 |
| inst_src1_o | output | FIELD_W | Field 2 |
| inst_src2_o | output | FIELD_W | Field 3 |
| inst_epoch_o | output | EPOCH_W | Epoch of the instruction |
| inst_next_pc_o | output | PC_W | Sequential next address |
| inst_pred_pc_o | output | PC_W | Predicted next address |

## Verification
The bench builds the block with LINE_BYTES at 8 rather than 16. This puts a line crossing every eight bytes, so mismatched and stale line addresses occur often under random traffic. MAX_BYTES stays at 64, and FIELD_W stays at 64. A directed run of 80 hold-set bytes therefore reaches the stall limit within about 70 cycles. In the same run, sixteen or more nibbles go into one field, which pushes bits off its top end. With a 32-bit address and 8-bit epoch, random restarts keep all traffic inside a 512-byte model memory.

// File: rtl/nia_pkg.sv
package nia_pkg;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned NUM_FIELDS = 4;

  typedef enum logic [1:0] {
    FLD_OPCODE    = 2'd0,
    FLD_FLAGS_DST = 2'd1,
    FLD_SRC1      = 2'd2,
    FLD_SRC2      = 2'd3
  } field_sel_e;

  typedef struct packed {
    logic       hold;
    logic       inv;
    field_sel_e sel;
    logic [3:0] nib;
  } enc_byte_t;
endpackage

// File: rtl/nia_byte_pick.sv
module nia_byte_pick
  import nia_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES)
) (
  input  logic [LINE_BYTES*8-1:0] line_i,
  input  logic [OFF_W-1:0]        off_i,
  output enc_byte_t               byte_o
);
  logic [7:0] slice [LINE_BYTES];

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_slice
    assign slice[b] = line_i[b*8 +: 8];
  end

  assign byte_o = enc_byte_t'(slice[off_i]);
endmodule

// File: rtl/nia_field_acc.sv
module nia_field_acc
  import nia_pkg::*;
#(
  parameter int unsigned FIELD_W = 64
) (
  input  logic [FIELD_W-1:0] field_q_i,
  input  logic               sel_i,
  input  logic               inv_i,
  input  logic [NIB_W-1:0]   nib_i,
  output logic [FIELD_W-1:0] field_d_o
);
  logic [FIELD_W-1:0] base;
  logic [FIELD_W-1:0] shifted;

  always_comb begin
    base      = inv_i ? ~field_q_i : field_q_i;
    shifted   = {base[FIELD_W-NIB_W-1:0], nib_i};
    field_d_o = sel_i ? shifted : field_q_i;
  end
endmodule

// File: rtl/nia_out_reg.sv
module nia_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      if (load_i) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nibble_inst_asm.sv
module nibble_inst_asm
  import nia_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned FIELD_W    = 64,
  parameter int unsigned EPOCH_W    = 8,
  parameter int unsigned MAX_BYTES  = 64,
  localparam int unsigned LINE_LOG2 = $clog2(LINE_BYTES),
  localparam int unsigned LADDR_W   = PC_W - LINE_LOG2,
  localparam int unsigned SIZE_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    restart_valid_i,
  input  logic [PC_W-1:0]         restart_pc_i,
  input  logic [EPOCH_W-1:0]      restart_epoch_i,
  input  logic                    bundle_valid_i,
  input  logic [LADDR_W-1:0]      bundle_line_i,
  input  logic [LINE_BYTES*8-1:0] bundle_data_i,
  output logic [PC_W-1:0]         decode_pc_o,
  output logic                    byte_take_o,
  output logic                    inst_valid_o,
  input  logic                    inst_ready_i,
  output logic [PC_W-1:0]         inst_start_pc_o,
  output logic [SIZE_W-1:0]       inst_size_o,
  output logic [FIELD_W-1:0]      inst_opcode_o,
  output logic [FIELD_W-1:0]      inst_flags_dst_o,
  output logic [FIELD_W-1:0]      inst_src1_o,
  output logic [FIELD_W-1:0]      inst_src2_o,
  output logic [EPOCH_W-1:0]      inst_epoch_o,
  output logic [PC_W-1:0]         inst_next_pc_o,
  output logic [PC_W-1:0]         inst_pred_pc_o
);
  localparam int unsigned PAY_W = 3*PC_W + SIZE_W + NUM_FIELDS*FIELD_W + EPOCH_W;

  logic [PC_W-1:0]    pc_q, start_q, pc_inc;
  logic [SIZE_W-1:0]  size_q, size_inc;
  logic [EPOCH_W-1:0] epoch_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_q, field_d;

  enc_byte_t cur;
  logic line_hit, slot_free, under_limit, take, emit;
  logic [PAY_W-1:0] pay_d, pay_q;

  nia_byte_pick #(.LINE_BYTES(LINE_BYTES)) u_pick (
    .line_i (bundle_data_i),
    .off_i  (pc_q[LINE_LOG2-1:0]),
    .byte_o (cur)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    nia_field_acc #(.FIELD_W(FIELD_W)) u_acc (
      .field_q_i (field_q[f]),
      .sel_i     (cur.sel == field_sel_e'(f)),
      .inv_i     (cur.inv),
      .nib_i     (cur.nib),
      .field_d_o (field_d[f])
    );
  end

  always_comb begin
    line_hit    = bundle_line_i == pc_q[PC_W-1:LINE_LOG2];
    slot_free   = !inst_valid_o || inst_ready_i;
    under_limit = size_q < SIZE_W'(MAX_BYTES);
    take        = bundle_valid_i && line_hit && slot_free && under_limit && !restart_valid_i;
    emit        = take && !cur.hold;
    pc_inc      = pc_q + PC_W'(1);
    size_inc    = size_q + SIZE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      start_q <= '0;
      size_q  <= '0;
      epoch_q <= '0;
      field_q <= '0;
    end else if (restart_valid_i) begin
      pc_q    <= restart_pc_i;
      start_q <= restart_pc_i;
      size_q  <= '0;
      epoch_q <= restart_epoch_i;
      field_q <= '0;
    end else if (take) begin
      pc_q <= pc_inc;
      if (emit) begin
        start_q <= pc_inc;
        size_q  <= '0;
        field_q <= '0;
      end else begin
        size_q  <= size_inc;
        field_q <= field_d;
      end
    end
  end

  // payload captures the completing byte's field update
  assign pay_d = {start_q, size_inc, field_d[0], field_d[1], field_d[2], field_d[3],
                  epoch_q, pc_inc, pc_inc};

  nia_out_reg #(.DATA_W(PAY_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (emit),
    .data_i  (pay_d),
    .ready_i (inst_ready_i),
    .valid_o (inst_valid_o),
    .data_o  (pay_q)
  );

  assign {inst_start_pc_o, inst_size_o, inst_opcode_o, inst_flags_dst_o, inst_src1_o,
          inst_src2_o, inst_epoch_o, inst_next_pc_o, inst_pred_pc_o} = pay_q;

  assign decode_pc_o = pc_q;
  assign byte_take_o = take;
endmodule

// File: rtl/nia_checker.sv
module nia_checker #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned FIELD_W    = 64,
  parameter int unsigned EPOCH_W    = 8,
  parameter int unsigned MAX_BYTES  = 64,
  localparam int unsigned LINE_LOG2 = $clog2(LINE_BYTES),
  localparam int unsigned LADDR_W   = PC_W - LINE_LOG2,
  localparam int unsigned SIZE_W    = $clog2(MAX_BYTES + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    restart_valid_i,
  input logic [PC_W-1:0]         restart_pc_i,
  input logic                    bundle_valid_i,
  input logic [LADDR_W-1:0]      bundle_line_i,
  input logic [LINE_BYTES*8-1:0] bundle_data_i,
  input logic [PC_W-1:0]         decode_pc_o,
  input logic                    byte_take_o,
  input logic                    inst_valid_o,
  input logic                    inst_ready_i,
  input logic [PC_W-1:0]         inst_start_pc_o,
  input logic [SIZE_W-1:0]       inst_size_o,
  input logic [FIELD_W-1:0]      inst_opcode_o,
  input logic [FIELD_W-1:0]      inst_src1_o,
  input logic [EPOCH_W-1:0]      inst_epoch_o,
  input logic [PC_W-1:0]         inst_next_pc_o,
  input logic [PC_W-1:0]         inst_pred_pc_o,
  input logic [SIZE_W-1:0]       size_i
);
  logic [7:0] cur_byte;
  assign cur_byte = bundle_data_i[{decode_pc_o[LINE_LOG2-1:0], 3'b000} +: 8];

  AST_TAKE_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take_o |-> bundle_valid_i && !restart_valid_i &&
      (bundle_line_i == decode_pc_o[PC_W-1:LINE_LOG2]) && (!inst_valid_o || inst_ready_i)); // R2

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take_o |=> decode_pc_o == $past(decode_pc_o) + PC_W'(1)); // R5

  AST_EMIT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take_o && !cur_byte[7] |=> inst_valid_o); // R6

  AST_NEXT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_valid_o |-> inst_next_pc_o == inst_start_pc_o + PC_W'(inst_size_o) &&
      inst_pred_pc_o == inst_next_pc_o); // R6

  AST_LIMIT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i >= SIZE_W'(MAX_BYTES) |-> !byte_take_o); // R8

  AST_SIZE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i <= SIZE_W'(MAX_BYTES)); // R8

  AST_RESTART_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_valid_i |=> decode_pc_o == $past(restart_pc_i) && size_i == '0); // R9

  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_valid_o && !inst_ready_i |=> inst_valid_o && $stable(inst_start_pc_o) &&
      $stable(inst_size_o) && $stable(inst_opcode_o) && $stable(inst_src1_o) &&
      $stable(inst_epoch_o)); // R10
endmodule

bind nibble_inst_asm nia_checker #(
  .PC_W(PC_W), .LINE_BYTES(LINE_BYTES), .FIELD_W(FIELD_W),
  .EPOCH_W(EPOCH_W), .MAX_BYTES(MAX_BYTES)
) u_nia_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_valid_i(restart_valid_i),
  .restart_pc_i(restart_pc_i), .bundle_valid_i(bundle_valid_i),
  .bundle_line_i(bundle_line_i), .bundle_data_i(bundle_data_i),
  .decode_pc_o(decode_pc_o), .byte_take_o(byte_take_o), .inst_valid_o(inst_valid_o),
  .inst_ready_i(inst_ready_i), .inst_start_pc_o(inst_start_pc_o),
  .inst_size_o(inst_size_o), .inst_opcode_o(inst_opcode_o), .inst_src1_o(inst_src1_o),
  .inst_epoch_o(inst_epoch_o), .inst_next_pc_o(inst_next_pc_o),
  .inst_pred_pc_o(inst_pred_pc_o), .size_i(size_q)
);

// File: tb/tb_nibble_inst_asm.sv
module tb_nibble_inst_asm;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, LB = 8, FW = 64, EW = 8, MAXB = 64;
  localparam int LL2 = 3, LAW = PC_W - LL2, SW = 7;

  logic clk = 0, rst_ni = 0;
  logic rv = 0, bv = 0, rdy = 0;
  logic [PC_W-1:0] rpc = '0;
  logic [EW-1:0] rep = '0;
  logic [LAW-1:0] bline = '0;
  logic [LB*8-1:0] bdata = '0;
  logic [PC_W-1:0] dpc, o_start, o_next, o_pred;
  logic take, ovalid;
  logic [SW-1:0] o_size;
  logic [FW-1:0] o_f0, o_f1, o_f2, o_f3;
  logic [EW-1:0] o_ep;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_inst_asm #(.PC_W(PC_W), .LINE_BYTES(LB), .FIELD_W(FW), .EPOCH_W(EW),
                    .MAX_BYTES(MAXB)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .restart_valid_i(rv), .restart_pc_i(rpc),
    .restart_epoch_i(rep), .bundle_valid_i(bv), .bundle_line_i(bline),
    .bundle_data_i(bdata), .decode_pc_o(dpc), .byte_take_o(take),
    .inst_valid_o(ovalid), .inst_ready_i(rdy), .inst_start_pc_o(o_start),
    .inst_size_o(o_size), .inst_opcode_o(o_f0), .inst_flags_dst_o(o_f1),
    .inst_src1_o(o_f2), .inst_src2_o(o_f3), .inst_epoch_o(o_ep),
    .inst_next_pc_o(o_next), .inst_pred_pc_o(o_pred));

  int checks = 0, fails = 0;
  logic [7:0] mem [512];

  // reference model
  logic [PC_W-1:0] m_pc, m_start;
  int m_size;
  logic [FW-1:0] m_f [4];
  logic [EW-1:0] m_ep;
  logic m_ov;
  logic [PC_W-1:0] mo_start;
  int mo_size;
  logic [FW-1:0] mo_f [4];
  logic [EW-1:0] mo_ep;

  task automatic chk(input string req, input string what, input logic [FW-1:0] act,
                     input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] acc(input logic [FW-1:0] f, input logic [7:0] b);
    logic [FW-1:0] x = b[6] ? ~f : f;
    return {x[FW-5:0], b[3:0]};
  endfunction

  function automatic logic m_take();
    return bv && (bline == m_pc[PC_W-1:LL2]) && (!m_ov || rdy) && (m_size < MAXB) && !rv;
  endfunction

  task automatic model_reset();
    m_pc = '0; m_start = '0; m_size = 0; m_ep = '0; m_ov = 0;
    for (int i = 0; i < 4; i++) m_f[i] = '0;
  endtask

  task automatic model_step();
    logic [7:0] b;
    logic t = m_take();
    b = bdata[m_pc[LL2-1:0]*8 +: 8];
    if (m_ov && rdy) m_ov = 0;
    if (rv) begin
      m_pc = rpc; m_start = rpc; m_size = 0; m_ep = rep;
      for (int i = 0; i < 4; i++) m_f[i] = '0;
    end else if (t) begin
      m_f[b[5:4]] = acc(m_f[b[5:4]], b);
      m_pc = m_pc + 1; m_size++;
      if (!b[7]) begin
        m_ov = 1; mo_start = m_start; mo_size = m_size; mo_ep = m_ep;
        for (int i = 0; i < 4; i++) begin mo_f[i] = m_f[i]; m_f[i] = '0; end
        m_start = m_pc; m_size = 0;
      end
    end
  endtask

  task automatic fill_line(input logic [LAW-1:0] ln);
    bline = ln;
    for (int i = 0; i < LB; i++) bdata[i*8 +: 8] = mem[(int'(ln)*LB + i) % 512];
  endtask

  task automatic compare_state();
    chk("R5", "decode_pc", FW'(dpc), FW'(m_pc));
    chk("R6", "inst_valid", FW'(ovalid), FW'(m_ov));
    if (m_ov) begin
      chk("R7", "start_pc", FW'(o_start), FW'(mo_start));
      chk("R7", "size", FW'(o_size), FW'(mo_size));
      chk("R4", "opcode", o_f0, mo_f[0]);
      chk("R4", "flags_dst", o_f1, mo_f[1]);
      chk("R4", "src1", o_f2, mo_f[2]);
      chk("R4", "src2", o_f3, mo_f[3]);
      chk("R9", "epoch", FW'(o_ep), FW'(mo_ep));
      chk("R6", "next_pc", FW'(o_next), FW'(mo_start + PC_W'(mo_size)));
      chk("R6", "pred_pc", FW'(o_pred), FW'(mo_start + PC_W'(mo_size)));
    end
  endtask

  // inputs are set after a negedge; this checks combinational take, steps, rechecks
  task automatic cycle();
    #1;
    chk("R2", "byte_take", FW'(take), FW'(m_take()));
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_state();
  endtask

  task automatic restart_to(input logic [PC_W-1:0] a, input logic [EW-1:0] e);
    rv = 1; rpc = a; rep = e; bv = 0;
    cycle();
    rv = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 512; i++)
      mem[i] = {($urandom % 4) != 0, 7'($urandom)};
    for (int i = 'h100; i < 'h150; i++) mem[i] = 8'h81;  // hold, opcode, nibble 1
    mem['h180] = 8'hE0;  // hold, invert, src1, 0
    mem['h181] = 8'h2A;  // last, src1, A

    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", "reset inst_valid", FW'(ovalid), '0);
    chk("R1", "reset decode_pc", FW'(dpc), '0);
    rst_ni = 1;

    // invert then shift: src1 = ~0 << 4 | 0, then << 4 | A
    restart_to(32'h180, 8'h05);
    rdy = 1; bv = 1;
    for (int c = 0; c < 4; c++) begin
      fill_line(m_pc[PC_W-1:LL2]);
      cycle();
    end
    rdy = 0; bv = 0;
    restart_to(32'h180, 8'h06);
    bv = 1;
    for (int c = 0; c < 3; c++) begin
      fill_line(m_pc[PC_W-1:LL2]);
      cycle();
    end
    chk("R3", "inverted src1", o_f2, 64'hFFFF_FFFF_FFFF_FF0A);
    chk("R3", "size 2", FW'(o_size), FW'(2));
    // slot full, no consumption, payload held
    for (int c = 0; c < 5; c++) begin
      fill_line(m_pc[PC_W-1:LL2]);
      cycle();
    end
    chk("R10", "held src1", o_f2, 64'hFFFF_FFFF_FFFF_FF0A);
    chk("R10", "held epoch", FW'(o_ep), FW'(8'h06));
    chk("R2", "pc frozen while slot full", FW'(dpc), FW'(32'h182));
    rdy = 1;

    // byte-count limit
    restart_to(32'h100, 8'h11);
    bv = 1;
    for (int c = 0; c < 90; c++) begin
      fill_line(m_pc[PC_W-1:LL2]);
      cycle();
    end
    chk("R8", "stalled pc", FW'(dpc), FW'(32'h140));
    chk("R8", "no emission", FW'(ovalid), '0);

    // restart during a usable byte
    restart_to(32'h20, 8'h22);
    fill_line(m_pc[PC_W-1:LL2]); bv = 1; rv = 1; rpc = 32'h40; rep = 8'h23;
    cycle();
    rv = 0;
    chk("R9", "restart wins", FW'(dpc), FW'(32'h40));

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      rv  = (($urandom % 40) == 0) || (m_pc > 440) ||
            (m_pc >= 'h100 && m_pc < 'h150);
      rpc = PC_W'($urandom % 400);
      if (rpc >= 'h100 && rpc < 'h150) rpc = rpc + 32'h60;
      rep = EW'($urandom);
      bv  = ($urandom % 8) != 0;
      rdy = ($urandom % 4) != 0;
      if (($urandom % 6) == 0) fill_line(LAW'($urandom % 64));
      else fill_line(m_pc[PC_W-1:LL2]);
      cycle();
    end
    rv = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule